// File: doc/BRIEF.md
# Vertical Blank Flag and Interrupt Generator

This block keeps the frame timing of a video display controller. A dot counter and a scanline counter sweep a 341 by 262 raster on every frame. When the raster enters the blanking region the block raises a vertical-blank flag. It then drives an active-low non-maskable interrupt toward the host processor whenever the host's interrupt enable and that flag are both set.

The host reaches the block through a small register port, with no stream. A write to the control register takes only its enable bit. A read of the status register returns the flag and clears it. The interrupt line is a live combination of the two state bits, not a one-shot pulse. So clearing and setting the enable again during blanking asserts the line once more, and a status read drops the line.

A status read and the flag's set point can fall on the same dot. The block settles that race in one fixed way: the read sees 0, and the flag and interrupt stay off for that frame.

Top module: `vbl_nmi_top`

## Requirements
- R1: `dot_pos` counts 0 to 340 and wraps to 0. On that wrap `line_pos` advances, and it wraps from 261 to 0.
- R2: The flag becomes 1 on the clock edge that moves the counters from line 240 dot 340 to line 241 dot 0. It is 1 only while `line_pos` is 241 or more.
- R3: The flag returns to 0 on the edge that moves the counters from line 261 dot 340 to line 0 dot 0.
- R4: A status read (`host_sel`=1, `host_wr`=0, `host_addr`=1) puts the flag on `host_rdata` bit 7 in the same cycle, with bits 6..0 at 0. With no status read in a cycle, `host_rdata` is 0.
- R5: A status read clears the flag on the next clock edge.
- R6: `nmi_n` is 0 exactly when the enable bit and the flag are both 1, and 1 otherwise.
- R7: With the enable already set, `nmi_n` falls as the counters reach line 241 dot 0.
- R8: Each 0-to-1 change of the enable bit while the flag is set drives `nmi_n` low again. Repeated toggles in one blanking period each produce an assertion.
- R9: A control write (`host_sel`=1, `host_wr`=1, `host_addr`=0) loads the enable from `host_wdata` bit 7. Bits 6..0 have no effect.
- R10: A status read in the cycle the counters show line 240 dot 340 returns 0. It keeps both the flag and `nmi_n` inactive for that frame.
- R11: A synchronous reset (`rst`=1) clears both counters, the flag and the enable bit, and leaves `nmi_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | Host access in this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 1 | 0 = control register, 1 = status register |
| host_wdata | input | 8 | Write data; bit 7 is the interrupt enable |
| host_rdata | output | 8 | Status read data; bit 7 is the vertical-blank flag |
| nmi_n | output | 1 | Active-low interrupt request |
| dot_pos | output | 9 | Current dot in the scanline |
| line_pos | output | 9 | Current scanline in the frame |

## Verification
The checker watches every cycle for five things: the counter carry into the next line, the flag rising at the blanking set point and dropping at frame end, the flag clearing after any status read, and the race read leaving the interrupt inactive. It also checks that the flag never appears outside the blanking lines. Whether `nmi_n` follows enable toggles, which enable bit is decoded and what the read data holds all depend on the order of host accesses. Only the bench's vector walk through one blanking period shows these. The bench also runs a second copy that is never read, to observe the end-of-frame clear in parallel.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
  // host register select on the single address pin
  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_STAT = 1'b1
  } host_reg_e;
endpackage

// File: rtl/wrap_ctr.sv
module wrap_ctr #(
  parameter int unsigned LIMIT = 341,
  localparam int unsigned W = $clog2(LIMIT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         last
);
  assign last = (value == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (step) value <= last ? '0 : value + 1'b1;
  end
endmodule

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int unsigned DOTS  = 341,
  parameter int unsigned LINES = 262,
  parameter int unsigned BLANK_LINE = 241,
  localparam int unsigned DW = $clog2(DOTS),
  localparam int unsigned LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] dot,
  output logic [LW-1:0] line,
  output logic          at_blank_set,
  output logic          at_frame_end
);
  logic dot_last, line_last;

  wrap_ctr #(.LIMIT(DOTS)) u_dot (
    .clk(clk), .rst(rst), .step(1'b1), .value(dot), .last(dot_last)
  );

  wrap_ctr #(.LIMIT(LINES)) u_line (
    .clk(clk), .rst(rst), .step(dot_last), .value(line), .last(line_last)
  );

  // last dot before the first blanking line, and last dot of the frame
  assign at_blank_set = dot_last && (line == LW'(BLANK_LINE - 1));
  assign at_frame_end = dot_last && line_last;
endmodule

// File: rtl/blank_flag.sv
module blank_flag (
  input  logic clk,
  input  logic rst,
  input  logic at_blank_set,
  input  logic at_frame_end,
  input  logic stat_rd,
  output logic vflag
);
  // priority: frame end, then set point (lost to a same-cycle read), then read clear
  always_ff @(posedge clk) begin
    if (rst)                           vflag <= 1'b0;
    else if (at_frame_end)             vflag <= 1'b0;
    else if (at_blank_set && !stat_rd) vflag <= 1'b1;
    else if (stat_rd)                  vflag <= 1'b0;
  end
endmodule

// File: rtl/host_port.sv
module host_port
  import vbl_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EN_BIT = 7,
  parameter int unsigned FLAG_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vflag,
  output logic [DATA_W-1:0] rdata,
  output logic              stat_rd,
  output logic              nmi_en
);
  logic ctrl_wr;
  logic unused_wbits;

  assign ctrl_wr = sel && wr && (host_reg_e'(addr) == REG_CTRL);
  assign stat_rd = sel && !wr && (host_reg_e'(addr) == REG_STAT);
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst)          nmi_en <= 1'b0;
    else if (ctrl_wr) nmi_en <= wdata[EN_BIT];
  end

  always_comb begin
    rdata = '0;
    if (stat_rd) rdata[FLAG_BIT] = vflag;
  end
endmodule

// File: rtl/vbl_nmi_top.sv
module vbl_nmi_top #(
  parameter int unsigned DOTS_PER_LINE = 341,
  parameter int unsigned LINES_PER_FRAME = 262,
  parameter int unsigned FIRST_BLANK_LINE = 241,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DW = $clog2(DOTS_PER_LINE),
  localparam int unsigned LW = $clog2(LINES_PER_FRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              nmi_n,
  output logic [DW-1:0]     dot_pos,
  output logic [LW-1:0]     line_pos
);
  logic at_blank_set, at_frame_end, stat_rd, vflag, nmi_en;

  raster_timer #(
    .DOTS(DOTS_PER_LINE), .LINES(LINES_PER_FRAME), .BLANK_LINE(FIRST_BLANK_LINE)
  ) u_timer (
    .clk(clk), .rst(rst), .dot(dot_pos), .line(line_pos),
    .at_blank_set(at_blank_set), .at_frame_end(at_frame_end)
  );

  blank_flag u_flag (
    .clk(clk), .rst(rst), .at_blank_set(at_blank_set),
    .at_frame_end(at_frame_end), .stat_rd(stat_rd), .vflag(vflag)
  );

  host_port #(.DATA_W(DATA_W), .EN_BIT(DATA_W - 1), .FLAG_BIT(DATA_W - 1)) u_port (
    .clk(clk), .rst(rst), .sel(host_sel), .wr(host_wr), .addr(host_addr),
    .wdata(host_wdata), .vflag(vflag), .rdata(host_rdata),
    .stat_rd(stat_rd), .nmi_en(nmi_en)
  );

  // level request: follows both state bits, so re-enabling re-asserts
  assign nmi_n = !(nmi_en && vflag);
endmodule

// File: rtl/vbl_nmi_chk.sv
module vbl_nmi_chk #(
  parameter int unsigned DOTS_PER_LINE = 341,
  parameter int unsigned LINES_PER_FRAME = 262,
  parameter int unsigned FIRST_BLANK_LINE = 241,
  localparam int unsigned DW = $clog2(DOTS_PER_LINE),
  localparam int unsigned LW = $clog2(LINES_PER_FRAME)
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] dot_pos,
  input logic [LW-1:0] line_pos,
  input logic          vflag,
  input logic          stat_rd,
  input logic          at_blank_set,
  input logic          at_frame_end,
  input logic          nmi_n
);
  // R1
  line_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (dot_pos == DW'(DOTS_PER_LINE - 1) && line_pos != LW'(LINES_PER_FRAME - 1))
    |=> (dot_pos == '0 && line_pos == $past(line_pos) + 1'b1));

  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (at_blank_set && !stat_rd) |=> vflag);

  // R2
  flag_region_chk: assert property (@(posedge clk) disable iff (rst)
    vflag |-> (line_pos >= LW'(FIRST_BLANK_LINE)));

  // R3
  frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
    at_frame_end |=> !vflag);

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> !vflag);

  // R10
  race_block_chk: assert property (@(posedge clk) disable iff (rst)
    (at_blank_set && stat_rd) |=> (nmi_n && !vflag));
endmodule

bind vbl_nmi_top vbl_nmi_chk #(
  .DOTS_PER_LINE(DOTS_PER_LINE), .LINES_PER_FRAME(LINES_PER_FRAME),
  .FIRST_BLANK_LINE(FIRST_BLANK_LINE)
) u_chk (
  .clk(clk), .rst(rst), .dot_pos(dot_pos), .line_pos(line_pos), .vflag(vflag),
  .stat_rd(stat_rd), .at_blank_set(at_blank_set), .at_frame_end(at_frame_end),
  .nmi_n(nmi_n)
);

// File: tb/test_vbl_nmi_top.sv
module test_vbl_nmi_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic nmi_n;
  logic [8:0] dot, line;
  logic b_sel = 1'b0, b_wr = 1'b0, b_addr = 1'b0;
  logic [7:0] b_wd = '0;
  logic [7:0] b_rd;
  logic b_nmi_n;
  logic [8:0] b_dot, b_line;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  vbl_nmi_top i_vbl_nmi_top (
    .clk(clk), .rst(rst), .host_sel(sel), .host_wr(wr), .host_addr(addr),
    .host_wdata(wd), .host_rdata(rd), .nmi_n(nmi_n), .dot_pos(dot), .line_pos(line)
  );

  // second copy, never read, for the end-of-frame clear (R3)
  vbl_nmi_top i_vbl_nmi_top_b (
    .clk(clk), .rst(rst), .host_sel(b_sel), .host_wr(b_wr), .host_addr(b_addr),
    .host_wdata(b_wd), .host_rdata(b_rd), .nmi_n(b_nmi_n), .dot_pos(b_dot),
    .line_pos(b_line)
  );

  // {req[3:0], op[1:0] (0 idle,1 ctrl write,2 status read), wdata, exp rdata, exp nmi_n after edge}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {4'd8, 2'd1, 8'h00, 8'h00, 1'b1},  // R8 enable off
    {4'd8, 2'd1, 8'h80, 8'h00, 1'b0},  // R8 re-enable asserts
    {4'd8, 2'd1, 8'h00, 8'h00, 1'b1},  // R8
    {4'd8, 2'd1, 8'h80, 8'h00, 1'b0},  // R8 second toggle asserts again
    {4'd9, 2'd1, 8'h7F, 8'h00, 1'b1},  // R9 low bits ignored
    {4'd9, 2'd1, 8'hFF, 8'h00, 1'b0},  // R9
    {4'd6, 2'd0, 8'h00, 8'h00, 1'b0},  // R6 idle holds
    {4'd4, 2'd2, 8'h00, 8'h80, 1'b1},  // R4 R5 read sees flag, clears it
    {4'd5, 2'd2, 8'h00, 8'h00, 1'b1},  // R5 flag gone
    {4'd6, 2'd1, 8'h00, 8'h00, 1'b1},  // R6
    {4'd6, 2'd1, 8'h80, 8'h00, 1'b1},  // R6 no flag, no request
    {4'd6, 2'd0, 8'h00, 8'h00, 1'b1}   // R6
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_pos(input int l, input int d);
    while (!(line == 9'(l) && dot == 9'(d))) @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] op, input logic [7:0] data);
    sel = (op != 2'd0);
    wr = (op == 2'd1);
    addr = (op == 2'd2);
    wd = data;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(dot == 0 && line == 0, "R11", {dot, line}, 0);
    check(nmi_n == 1'b1, "R11", nmi_n, 1);
    rst = 1'b0;
    drive(2'd1, 8'h80);
    b_sel = 1'b1; b_wr = 1'b1; b_addr = 1'b0; b_wd = 8'h80;
    @(negedge clk);
    drive(2'd0, 8'h00);
    b_sel = 1'b0; b_wr = 1'b0;
    check(nmi_n == 1'b1, "R6", nmi_n, 1);  // R6 enable alone
    // R1 line carry
    wait_pos(0, 340);
    @(negedge clk);
    check(dot == 0 && line == 1, "R1", {dot, line}, {9'd0, 9'd1});
    // R7 R2 blanking entry with enable already set
    wait_pos(240, 340);
    check(nmi_n == 1'b1, "R7", nmi_n, 1);
    @(negedge clk);
    check(line == 241 && dot == 0, "R2", {line, dot}, {9'd241, 9'd0});
    check(nmi_n == 1'b0, "R7", nmi_n, 0);
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      drive(v[18:17], v[16:9]);
      #1;
      if (v[18:17] == 2'd2)
        check(rd == v[8:1], $sformatf("R%0d", v[22:19]), rd, v[8:1]);
      @(negedge clk);
      drive(2'd0, 8'h00);
      check(nmi_n == v[0], $sformatf("R%0d", v[22:19]), nmi_n, v[0]);
    end
    sel = 1'b0;
    // R3 on the unread copy
    wait_pos(261, 340);
    check(b_nmi_n == 1'b0, "R6", b_nmi_n, 0);
    @(negedge clk);
    check(line == 0 && dot == 0, "R1", {line, dot}, 0);
    check(b_nmi_n == 1'b1, "R3", b_nmi_n, 1);
    b_sel = 1'b1; b_wr = 1'b0; b_addr = 1'b1;
    #1;
    check(b_rd == 8'h00, "R3", b_rd, 0);
    @(negedge clk);
    b_sel = 1'b0;
    // R10 race read on the set dot, enable still on
    wait_pos(240, 340);
    drive(2'd2, 8'h00);
    #1;
    check(rd == 8'h00, "R10", rd, 0);
    @(negedge clk);
    drive(2'd0, 8'h00);
    check(nmi_n == 1'b1, "R10", nmi_n, 1);
    check(b_nmi_n == 1'b0, "R7", b_nmi_n, 0);
    drive(2'd2, 8'h00);
    #1;
    check(rd == 8'h00, "R10", rd, 0);
    @(negedge clk);
    drive(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    check(nmi_n == 1'b1, "R10", nmi_n, 1);
    finish_run();
  end
endmodule